// File: doc/BRIEF.md
# Control Endpoint OUT Transfer Tracker

This block keeps the transfer bookkeeping for the OUT direction of a USB device control endpoint. Before enabling the endpoint, software loads three fields through a 32-bit register port: a byte budget for the transfer, a one-bit packet counter and a two-bit allowance of back-to-back SETUP packets. Once the endpoint is enabled, the hardware owns these fields. Software writes are then dropped, and each packet committed to the receive FIFO takes its byte count off the budget.

The transfer is complete when the budget is used up or when a packet shorter than the maximum packet size arrives. At that point the block drops the endpoint enable and raises a one-cycle interrupt. Setting the budget equal to the maximum packet size therefore gives one interrupt per packet. SETUP arrivals draw down their own allowance, which does not depend on the data counters. While scatter/gather mode is on, the register is hidden: writes are dropped and reads return zero.

Top module: `ctl_out_xfer_tracker`

## Requirements
- R1: After reset, the endpoint is not enabled, the interrupt is low, and reading the register returns 0.
- R2: The register holds the byte budget in bits 6:0, the packet counter in bit 19 and the SETUP allowance in bits 29:28. All other bits read 0 and ignore writes. Read data appears on `reg_rdata` one cycle after the `reg_rd` strobe and holds until the next read.
- R3: A commit while the endpoint is enabled lowers the byte budget by `pkt_bytes`, with the result saturating at 0, and clears the packet counter.
- R4: A commit while enabled ends the transfer when the new budget is 0 or when `pkt_bytes` is less than MAX_PKT. Ending the transfer drops `ep_active` at the same edge.
- R5: `xfer_irq` is high for exactly the one cycle after a transfer-ending commit. A full-size commit that leaves budget remaining raises no interrupt.
- R6: Each `setup_rcvd` strobe lowers the SETUP allowance by one, with the result saturating at 0.
- R7: While `sg_mode` is 1, register writes are dropped and reads return 0.
- R8: Register writes while `ep_active` is 1 are dropped. A pulse on `ep_en_req` sets `ep_active`.
- R9: A commit while the endpoint is not enabled changes no field and raises no interrupt.
- R10: A read in the same cycle as a commit returns the field values from before that commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Registered read data |
| ep_en_req | input | 1 | Pulse that enables the endpoint |
| ep_active | output | 1 | Endpoint enabled; hardware owns the fields |
| pkt_commit | input | 1 | A received packet was written to the receive FIFO |
| pkt_bytes | input | 7 | Byte count of the committed packet |
| setup_rcvd | input | 1 | A SETUP packet was received |
| sg_mode | input | 1 | Scatter/gather mode active |
| xfer_irq | output | 1 | One-cycle transfer-complete pulse |

## Verification
The assertions watch every cycle for the following:
- the budget never rises while the endpoint is enabled, and it locks when no commit arrives;
- a completing commit drops the enable and is followed by a single-cycle interrupt;
- the SETUP allowance stays at zero once it reaches zero;
- reads return zero under scatter/gather mode and never show reserved bits.

Only the bench scenarios can show the exact arithmetic:
- the remaining budget after specific byte counts;
- completion on short packets;
- the pre-update value returned by a read that collides with a commit;
- the write and commit paths being ignored in each locked state.

// File: rtl/ctl_out_pkg.sv
package ctl_out_pkg;
  localparam int XFER_W    = 7;
  localparam int SUP_W     = 2;
  localparam int REG_W     = 32;
  localparam int XFER_LSB  = 0;
  localparam int PKT_BIT   = 19;
  localparam int SUP_LSB   = 28;

  typedef struct packed {
    logic [SUP_W-1:0]  sup;
    logic              pkt;
    logic [XFER_W-1:0] size;
  } ep_fields_t;

  function automatic logic [XFER_W-1:0] sat_sub(input logic [XFER_W-1:0] a,
                                                input logic [XFER_W-1:0] b);
    return (b >= a) ? '0 : a - b;
  endfunction

  function automatic logic [SUP_W-1:0] dec_floor(input logic [SUP_W-1:0] a);
    return (a == '0) ? '0 : a - 1'b1;
  endfunction

  function automatic logic [REG_W-1:0] pack_view(input ep_fields_t f);
    logic [REG_W-1:0] w;
    w = '0;
    w[XFER_LSB +: XFER_W] = f.size;
    w[PKT_BIT]            = f.pkt;
    w[SUP_LSB +: SUP_W]   = f.sup;
    return w;
  endfunction

  function automatic ep_fields_t unpack_view(input logic [REG_W-1:0] w);
    ep_fields_t f;
    f.size = w[XFER_LSB +: XFER_W];
    f.pkt  = w[PKT_BIT];
    f.sup  = w[SUP_LSB +: SUP_W];
    return f;
  endfunction

  function automatic logic [REG_W-1:0] field_mask();
    ep_fields_t ones;
    ones.size = '1;
    ones.pkt  = 1'b1;
    ones.sup  = '1;
    return pack_view(ones);
  endfunction
endpackage

// File: rtl/ctl_out_xfer_unit.sv
module ctl_out_xfer_unit
  import ctl_out_pkg::*;
#(
  parameter int MAX_PKT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [XFER_W-1:0] load_size,
  input  logic              load_pkt,
  input  logic              active,
  input  logic              commit,
  input  logic [XFER_W-1:0] bytes,
  output logic [XFER_W-1:0] size,
  output logic              pkt,
  output logic              done_evt
);
  localparam logic [XFER_W-1:0] MPS = XFER_W'(MAX_PKT);

  logic [XFER_W-1:0] size_next;
  logic              take;
  logic              short_pkt;

  assign take      = active && commit;
  assign size_next = sat_sub(size, bytes);
  assign short_pkt = bytes < MPS;
  assign done_evt  = take && ((size_next == '0) || short_pkt);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size <= '0;
      pkt  <= 1'b0;
    end else if (load) begin
      size <= load_size;
      pkt  <= load_pkt;
    end else if (take) begin
      size <= size_next;
      pkt  <= 1'b0;
    end
  end
endmodule

// File: rtl/ctl_out_setup_unit.sv
module ctl_out_setup_unit
  import ctl_out_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SUP_W-1:0] load_val,
  input  logic             dec,
  output logic [SUP_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (dec)
      cnt <= dec_floor(cnt);
  end
endmodule

// File: rtl/ctl_out_enable_unit.sv
module ctl_out_enable_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic en_req,
  input  logic done_evt,
  output logic active,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= done_evt;
      if (done_evt)
        active <= 1'b0;
      else if (en_req)
        active <= 1'b1;
    end
  end
endmodule

// File: rtl/ctl_out_read_unit.sv
module ctl_out_read_unit
  import ctl_out_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  logic             hide,
  input  ep_fields_t       fields,
  output logic [REG_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      rdata <= '0;
    else if (rd)
      rdata <= hide ? '0 : pack_view(fields);
  end
endmodule

// File: rtl/ctl_out_xfer_tracker.sv
module ctl_out_xfer_tracker
  import ctl_out_pkg::*;
#(
  parameter int MAX_PKT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              reg_rd,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic              ep_en_req,
  output logic              ep_active,
  input  logic              pkt_commit,
  input  logic [XFER_W-1:0] pkt_bytes,
  input  logic              setup_rcvd,
  input  logic              sg_mode,
  output logic              xfer_irq
);
  ep_fields_t        wr_fields;
  ep_fields_t        cur_fields;
  logic              sw_wr_ok;
  logic              done_evt;
  logic [XFER_W-1:0] cur_size;
  logic              cur_pkt;
  logic [SUP_W-1:0]  cur_setup;

  assign wr_fields = unpack_view(reg_wdata);
  assign sw_wr_ok  = reg_wr && !sg_mode && !ep_active;

  ctl_out_xfer_unit #(.MAX_PKT(MAX_PKT)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (sw_wr_ok),
    .load_size (wr_fields.size),
    .load_pkt  (wr_fields.pkt),
    .active    (ep_active),
    .commit    (pkt_commit),
    .bytes     (pkt_bytes),
    .size      (cur_size),
    .pkt       (cur_pkt),
    .done_evt  (done_evt)
  );

  ctl_out_setup_unit u_setup (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sw_wr_ok),
    .load_val (wr_fields.sup),
    .dec      (setup_rcvd),
    .cnt      (cur_setup)
  );

  ctl_out_enable_unit u_enable (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_req   (ep_en_req),
    .done_evt (done_evt),
    .active   (ep_active),
    .irq      (xfer_irq)
  );

  always_comb begin
    cur_fields.size = cur_size;
    cur_fields.pkt  = cur_pkt;
    cur_fields.sup  = cur_setup;
  end

  ctl_out_read_unit u_read (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd     (reg_rd),
    .hide   (sg_mode),
    .fields (cur_fields),
    .rdata  (reg_rdata)
  );
endmodule

// File: rtl/ctl_out_xfer_tracker_chk.sv
module ctl_out_xfer_tracker_chk
  import ctl_out_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic              reg_rd,
  input logic [REG_W-1:0]  reg_rdata,
  input logic              ep_active,
  input logic              pkt_commit,
  input logic [XFER_W-1:0] pkt_bytes,
  input logic              setup_rcvd,
  input logic              sg_mode,
  input logic              xfer_irq,
  input logic              sw_wr_ok,
  input logic              done_evt,
  input logic [XFER_W-1:0] cur_size,
  input logic              cur_pkt,
  input logic [SUP_W-1:0]  cur_setup
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rdata & ~field_mask()) == '0);

  a_r3_size_never_rises: assert property (@(posedge clk) disable iff (!rst_n)
    ep_active |=> cur_size <= $past(cur_size));

  a_r3_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_active && pkt_commit && pkt_bytes >= cur_size) |=> cur_size == '0);

  a_r4_done_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> !ep_active);

  a_r5_irq_follows_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> xfer_irq);

  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_irq |=> !xfer_irq);

  a_r6_setup_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (setup_rcvd && !sw_wr_ok && cur_setup == '0) |=> cur_setup == '0);

  a_r7_sg_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && sg_mode) |=> reg_rdata == '0);

  a_r8_locked_fields: assert property (@(posedge clk) disable iff (!rst_n)
    (ep_active && !pkt_commit) |=> ($stable(cur_size) && $stable(cur_pkt)));

  a_r9_idle_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (!ep_active && !reg_wr && pkt_commit) |=> ($stable(cur_size) && !xfer_irq));
endmodule

bind ctl_out_xfer_tracker ctl_out_xfer_tracker_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_rdata  (reg_rdata),
  .ep_active  (ep_active),
  .pkt_commit (pkt_commit),
  .pkt_bytes  (pkt_bytes),
  .setup_rcvd (setup_rcvd),
  .sg_mode    (sg_mode),
  .xfer_irq   (xfer_irq),
  .sw_wr_ok   (sw_wr_ok),
  .done_evt   (done_evt),
  .cur_size   (cur_size),
  .cur_pkt    (cur_pkt),
  .cur_setup  (cur_setup)
);

// File: tb/test_ctl_out_xfer_tracker.sv
`timescale 1ns/1ps
module test_ctl_out_xfer_tracker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_rdata;
  logic        ep_en_req = 1'b0;
  logic        ep_active;
  logic        pkt_commit = 1'b0;
  logic [6:0]  pkt_bytes = '0;
  logic        setup_rcvd = 1'b0;
  logic        sg_mode = 1'b0;
  logic        xfer_irq;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #2.5 clk = ~clk;

  ctl_out_xfer_tracker #(.MAX_PKT(64)) i_ctl_out_xfer_tracker (.*);

  // Vector: {initial budget, packet bytes, expected budget, expected done}
  localparam int NV = 6;
  localparam logic [21:0] VEC [NV] = '{
    {7'd100, 7'd64, 7'd36, 1'b0},
    {7'd64,  7'd64, 7'd0,  1'b1},
    {7'd30,  7'd64, 7'd0,  1'b1},
    {7'd100, 7'd10, 7'd90, 1'b1},
    {7'd127, 7'd64, 7'd63, 1'b0},
    {7'd64,  7'd0,  7'd64, 1'b1}
  };

  function automatic logic [31:0] mk(input int sup, input int pkt, input int size);
    return (32'(sup & 3) << 28) | (32'(pkt & 1) << 19) | 32'(size & 127);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    reg_wr = 1'b1; reg_wdata = d; cyc(); reg_wr = 1'b0;
  endtask

  task automatic rd(output logic [31:0] d);
    reg_rd = 1'b1; cyc(); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic enable();
    ep_en_req = 1'b1; cyc(); ep_en_req = 1'b0;
  endtask

  task automatic commit(input int b);
    pkt_commit = 1'b1; pkt_bytes = 7'(b); cyc(); pkt_commit = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected < 20000 cycles", cycles);
      finish_run();
    end
  end

  initial begin
    logic [31:0] r;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
    // R1 reset state
    check("R1 ep_active", 32'(ep_active), 0);
    check("R1 irq", 32'(xfer_irq), 0);
    rd(r); check("R1 read", r, 0);

    // R2 layout, reserved bits
    wr(32'hFFFF_FFFF); rd(r); check("R2 layout", r, 32'h3008_007F);

    // Vector loop: R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      int init_sz, bytes, exp_sz;
      logic exp_done;
      init_sz  = int'(VEC[i][21:15]);
      bytes    = int'(VEC[i][14:8]);
      exp_sz   = int'(VEC[i][7:1]);
      exp_done = VEC[i][0];
      wr(mk(0, 1, init_sz));
      enable();
      check("R8 enable sets active", 32'(ep_active), 1);
      commit(bytes);
      check("R5 irq after commit", 32'(xfer_irq), 32'(exp_done));
      check("R4 active after commit", 32'(ep_active), 32'(!exp_done));
      cyc();
      check("R5 irq one cycle", 32'(xfer_irq), 0);
      rd(r);
      check("R3 budget and packet count", r, mk(0, 0, exp_sz));
      if (ep_active) begin
        commit(0);
        check("R4 short packet closes", 32'(ep_active), 0);
      end
    end

    // R8 writes dropped while enabled
    wr(mk(0, 1, 50)); enable();
    wr(mk(3, 0, 5)); rd(r);
    check("R8 write while active", r, mk(0, 1, 50));

    // R10 read colliding with commit returns pre-update
    reg_rd = 1'b1; pkt_commit = 1'b1; pkt_bytes = 7'd64; cyc();
    reg_rd = 1'b0; pkt_commit = 1'b0;
    check("R10 pre-update read", reg_rdata, mk(0, 1, 50));
    rd(r); check("R10 post-update read", r, mk(0, 0, 0));

    // R9 commit while not enabled
    wr(mk(0, 1, 40)); commit(64);
    check("R9 no irq", 32'(xfer_irq), 0);
    rd(r); check("R9 fields unchanged", r, mk(0, 1, 40));

    // R6 SETUP allowance
    wr(mk(2, 0, 0));
    setup_rcvd = 1'b1; cyc(); setup_rcvd = 1'b0;
    rd(r); check("R6 one setup", r, mk(1, 0, 0));
    setup_rcvd = 1'b1; cyc(); cyc(); cyc(); setup_rcvd = 1'b0;
    rd(r); check("R6 setup saturates", r, mk(0, 0, 0));

    // R7 scatter/gather hides the register
    wr(mk(1, 1, 77));
    sg_mode = 1'b1;
    wr(mk(3, 0, 9));
    rd(r); check("R7 read zero", r, 0);
    sg_mode = 1'b0;
    rd(r); check("R7 write dropped", r, mk(1, 1, 77));

    finish_run();
  end
endmodule